// File: doc/BRIEF.md
# Address Breakpoint and Watchpoint Unit

This block watches two CPU buses, the instruction-fetch address and the data-access address with its read and write strobes. When an access matches the programmed addresses, it asks the CPU to stop. Two address registers and a control register are written through a small register port. A control field chooses which kinds of access are watched: data reads, data writes, instruction fetches, or any mix of them. A separate bit turns the whole unit on or off.

By default each address register matches on its own, by equality. When range mode is built in and selected, the pair becomes an inclusive window. The first address register is the lower bound and the second is the upper bound. Any qualified access inside the window matches.

A match sets a sticky pending flag, which stays set until software writes 1 to it. A one-cycle halt request goes to the CPU in the cycle the flag goes from 0 to 1.

Top module: `hwbrk_unit`

## Requirements
- R1: After a synchronous active-low reset, the control register, both address registers and the pending flag read 0, and halt_req is low.
- R2: Register offsets on reg_addr are 0 for control (bits [4:0]), 1 for status (bit 0 is pending), 2 for address A and 3 for address B. Unused bits read 0. Control bits: 0 = watch reads, 1 = watch writes, 2 = unit enable, 3 = watch fetches, 4 = range mode.
- R3: With control bits 2 and 0 set, a data read (rd_vld) whose data_addr matches sets the pending flag at the next clock edge.
- R4: A data write (wr_vld) matches only when control bit 1 is set. A write with only bit 0 set leaves the flag clear.
- R5: An instruction fetch (fetch_vld with fetch_addr) matches only when control bit 3 is set. A data read does not match when only bit 3 is enabled.
- R6: With control bit 2 clear, no access of any kind sets the pending flag.
- R7: With range mode off, an access matches only when its address equals address A or address B. An address strictly between them does not match.
- R8: With range mode on, an access matches when A <= address <= B, both bounds included, and addresses outside the window do not match. When the build parameter RANGE_EN is 0, control bit 4 reads as 0 and has no effect.
- R9: The pending flag is sticky. Writing 1 to status bit 0 clears it. A match in the same cycle as the clear leaves it set.
- R10: halt_req is high for exactly one cycle, the cycle in which the pending flag goes from 0 to 1. A match while the flag is already set raises no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| fetch_vld | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | 16 | Instruction fetch address |
| rd_vld | input | 1 | Data read in this cycle |
| wr_vld | input | 1 | Data write in this cycle |
| data_addr | input | 16 | Data access address |
| brk_pending | output | 1 | Sticky pending flag |
| halt_req | output | 1 | One-cycle halt request to the CPU |

## Verification
The compare logic is tried with reads, writes and fetches at address A, at address B, at an address between them, and at the addresses just outside each bound. Each of these is repeated under different qualifier settings, so that a wrong qualifier bit and an equality test that is too loose give different results. Range mode is tried at both bounds and at their outer neighbours, which separates an inclusive bound from an exclusive or off-by-one one. A second instance built without range mode runs the same window access, which shows that bit 4 has no effect there. A hit in the same cycle as a clear, and a repeated hit while the flag is already set, separate the sticky flag and the edge-triggered halt from a level-driven version.

// File: rtl/hwbrk_pkg.sv
// Shared offsets and control bit positions for the breakpoint unit.
// Assumes a 2-bit register offset and a 5-bit control field.
package hwbrk_pkg;
    localparam int CTRL_W = 5;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_ADRA = 2'd2;
    localparam logic [1:0] OFS_ADRB = 2'd3;

    localparam int B_RD  = 0;
    localparam int B_WR  = 1;
    localparam int B_EN  = 2;
    localparam int B_FE  = 3;
    localparam int B_RNG = 4;
endpackage

// File: rtl/hwbrk_regs.sv
// Register file: control and two address registers, a write-one-to-clear
// strobe for the status flag, and the read mux.
// Assumes DW >= AW and DW >= CTRL_W. Reads are combinational.
module hwbrk_regs
    import hwbrk_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              pend,
    output logic [CTRL_W-1:0] ctrl,
    output logic [AW-1:0]     adr_a,
    output logic [AW-1:0]     adr_b,
    output logic              clr,
    output logic [DW-1:0]     reg_rdata
);
    localparam logic [CTRL_W-1:0] CTRL_MASK = {RANGE_EN, {(CTRL_W-1){1'b1}}};

    // Purpose: store the control and address registers on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            adr_a <= '0;
            adr_b <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL: ctrl  <= reg_wdata[CTRL_W-1:0] & CTRL_MASK;
                OFS_ADRA: adr_a <= reg_wdata[AW-1:0];
                OFS_ADRB: adr_b <= reg_wdata[AW-1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: decode the write-one-to-clear strobe for the status flag.
    always_comb clr = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[0];

    // Purpose: select the register addressed by reg_addr for reading.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
            OFS_STAT: reg_rdata[0]          = pend;
            OFS_ADRA: reg_rdata[AW-1:0]     = adr_a;
            default:  reg_rdata[AW-1:0]     = adr_b;
        endcase
    end
endmodule

// File: rtl/hwbrk_cmp.sv
// Address comparator for one bus. With RANGE_EN set it can test an
// inclusive window [lo, hi]; otherwise it only tests equality with either
// address and ignores rng_sel.
module hwbrk_cmp #(
    parameter int AW       = 16,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic          acc,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          rng_sel,
    output logic          hit
);
    logic eq_any;

    // Purpose: equality match with either stored address.
    always_comb eq_any = (addr == lo) || (addr == hi);

    generate
        if (RANGE_EN) begin : g_rng
            logic in_win;
            // Purpose: inclusive window test, with the mode selected by rng_sel.
            always_comb begin
                in_win = (addr >= lo) && (addr <= hi);
                hit    = acc && (rng_sel ? in_win : eq_any);
            end
        end else begin : g_eq
            logic unused_sel;
            // Purpose: equality-only variant.
            always_comb begin
                unused_sel = rng_sel;
                hit        = acc && eq_any;
            end
        end
    endgenerate
endmodule

// File: rtl/hwbrk_pend.sv
// Sticky pending flag with write-one-to-clear, and a one-cycle halt pulse
// on its rising edge. A set and a clear in the same cycle leave the flag set.
module hwbrk_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pend,
    output logic halt
);
    logic pend_nxt;

    // Purpose: next value of the flag, where a set beats a clear.
    always_comb pend_nxt = (pend & ~clr) | hit;

    // Purpose: register the flag and pulse halt when it goes from 0 to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            halt <= 1'b0;
        end else begin
            pend <= pend_nxt;
            halt <= pend_nxt & ~pend;
        end
    end
endmodule

// File: rtl/hwbrk_unit.sv
// Top of the breakpoint unit. Qualifies fetch and data accesses with the
// control bits, compares their addresses, and drives the pending flag and
// the halt request. All logic is on one clock with synchronous reset.
module hwbrk_unit
    import hwbrk_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_addr,
    input  logic          rd_vld,
    input  logic          wr_vld,
    input  logic [AW-1:0] data_addr,
    output logic          brk_pending,
    output logic          halt_req
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [AW-1:0]     adr_a, adr_b;
    logic              pend_clr;
    logic              data_acc, fetch_acc;
    logic              data_hit, fetch_hit, any_hit;

    hwbrk_regs #(.AW(AW), .DW(DW), .RANGE_EN(RANGE_EN)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pend(brk_pending), .ctrl(ctrl_q),
        .adr_a(adr_a), .adr_b(adr_b), .clr(pend_clr), .reg_rdata(reg_rdata)
    );

    // Purpose: qualify each bus with its watch bits.
    always_comb begin
        data_acc  = (ctrl_q[B_RD] & rd_vld) | (ctrl_q[B_WR] & wr_vld);
        fetch_acc = ctrl_q[B_FE] & fetch_vld;
    end

    hwbrk_cmp #(.AW(AW), .RANGE_EN(RANGE_EN)) u_cmp_data (
        .acc(data_acc), .addr(data_addr), .lo(adr_a), .hi(adr_b),
        .rng_sel(ctrl_q[B_RNG]), .hit(data_hit)
    );

    hwbrk_cmp #(.AW(AW), .RANGE_EN(RANGE_EN)) u_cmp_fetch (
        .acc(fetch_acc), .addr(fetch_addr), .lo(adr_a), .hi(adr_b),
        .rng_sel(ctrl_q[B_RNG]), .hit(fetch_hit)
    );

    // Purpose: gate both compare results with the unit enable.
    always_comb any_hit = ctrl_q[B_EN] & (data_hit | fetch_hit);

    hwbrk_pend u_pend (
        .clk(clk), .rst_n(rst_n), .hit(any_hit), .clr(pend_clr),
        .pend(brk_pending), .halt(halt_req)
    );
endmodule

// File: rtl/hwbrk_chk.sv
// Checker for the pending flag and the halt pulse, bound into hwbrk_unit.
module hwbrk_chk (
    input logic clk,
    input logic rst_n,
    input logic hit,
    input logic clr,
    input logic brk_pending,
    input logic halt_req
);
    a_r10_halt_with_pend: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> brk_pending);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req);
    a_r10_rise_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_pending) |-> halt_req);
    a_r9_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> brk_pending);
    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pending && clr && !hit) |=> !brk_pending);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pending && !clr) |=> brk_pending);
endmodule

bind hwbrk_unit hwbrk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hit(any_hit), .clr(pend_clr),
    .brk_pending(brk_pending), .halt_req(halt_req)
);

// File: tb/tb_hwbrk_unit.sv
module tb_hwbrk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_addr = 16'd0;
    logic        rd_vld = 1'b0;
    logic        wr_vld = 1'b0;
    logic [15:0] data_addr = 16'd0;
    logic [15:0] reg_rdata, rdata_nr;
    logic        brk_pending, halt_req, pend_nr, halt_nr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hwbrk_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .rd_vld(rd_vld), .wr_vld(wr_vld),
        .data_addr(data_addr), .brk_pending(brk_pending), .halt_req(halt_req)
    );

    hwbrk_unit #(.RANGE_EN(1'b0)) dut_nr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nr), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .rd_vld(rd_vld), .wr_vld(wr_vld),
        .data_addr(data_addr), .brk_pending(pend_nr), .halt_req(halt_nr)
    );

    // Behavioural reference model of the default build
    logic [4:0]  m_ctrl;
    logic [15:0] m_a, m_b;
    logic        m_pend, m_halt;

    function automatic logic model_match(input logic [15:0] ad);
        if (m_ctrl[4]) return (ad >= m_a) && (ad <= m_b);
        return (ad == m_a) || (ad == m_b);
    endfunction

    always @(posedge clk) begin
        logic hit, clr, nxt;
        if (!rst_n) begin
            m_ctrl = 0; m_a = 0; m_b = 0; m_pend = 0; m_halt = 0;
        end else begin
            hit = 1'b0;
            if (m_ctrl[2]) begin
                if (((m_ctrl[0] && rd_vld) || (m_ctrl[1] && wr_vld)) && model_match(data_addr)) hit = 1'b1;
                if (m_ctrl[3] && fetch_vld && model_match(fetch_addr)) hit = 1'b1;
            end
            clr = reg_wr && reg_addr == 2'd1 && reg_wdata[0];
            nxt = hit ? 1'b1 : (clr ? 1'b0 : m_pend);
            m_halt = nxt && !m_pend;
            m_pend = nxt;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata[4:0];
                    2'd2: m_a = reg_wdata;
                    2'd3: m_b = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] model_rdata();
        case (reg_addr)
            2'd0: return {11'd0, m_ctrl};
            2'd1: return {15'd0, m_pend};
            2'd2: return m_a;
            default: return m_b;
        endcase
    endfunction

    // Compare against the model 5 ns after every rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            n_cmp++;
            if (brk_pending !== m_pend) begin
                n_bad++;
                $display("FAIL R9 model pending: got %0b exp %0b", brk_pending, m_pend);
            end
            n_cmp++;
            if (halt_req !== m_halt) begin
                n_bad++;
                $display("FAIL R10 model halt: got %0b exp %0b", halt_req, m_halt);
            end
            n_cmp++;
            if (reg_rdata !== model_rdata()) begin
                n_bad++;
                $display("FAIL R2 model rdata: got %h exp %h", reg_rdata, model_rdata());
            end
        end
    end

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [1:0] ra, input logic [15:0] wd,
                         input logic fv, input logic rv, input logic wv,
                         input logic [15:0] fa, input logic [15:0] da);
        @(negedge clk);
        reg_wr = w; reg_addr = ra; reg_wdata = wd;
        fetch_vld = fv; rd_vld = rv; wr_vld = wv; fetch_addr = fa; data_addr = da;
        @(posedge clk);
        #6;
    endtask

    task automatic wreg(input logic [1:0] ra, input logic [15:0] wd);
        drive(1'b1, ra, wd, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
    endtask

    task automatic rreg(input logic [1:0] ra);
        drive(1'b0, ra, 16'd0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
    endtask

    task automatic dread(input logic [15:0] da);
        drive(1'b0, 2'd1, 16'd0, 1'b0, 1'b1, 1'b0, 16'd0, da);
    endtask

    task automatic clear_flag();
        wreg(2'd1, 16'h0001);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values
        for (int i = 0; i < 4; i++) begin
            rreg(i[1:0]);
            check(reg_rdata, 16'd0, "R1 reset register");
        end
        check({15'd0, halt_req}, 16'd0, "R1 halt low");
        // R2 register access
        wreg(2'd2, 16'h1234);
        wreg(2'd3, 16'h1240);
        wreg(2'd0, 16'hFFFF);
        rreg(2'd0); check(reg_rdata, 16'h001F, "R2 ctrl unused bits");
        wreg(2'd0, 16'h0005);
        rreg(2'd2); check(reg_rdata, 16'h1234, "R2 addr A");
        rreg(2'd3); check(reg_rdata, 16'h1240, "R2 addr B");
        // R3 read match and R10 pulse
        dread(16'h1234);
        check({15'd0, brk_pending}, 16'd1, "R3 read match");
        check({15'd0, halt_req}, 16'd1, "R10 halt on rise");
        rreg(2'd1);
        check({15'd0, halt_req}, 16'd0, "R10 halt one cycle");
        check({15'd0, brk_pending}, 16'd1, "R9 sticky");
        dread(16'h1234);
        check({15'd0, halt_req}, 16'd0, "R10 no halt while pending");
        clear_flag();
        check({15'd0, brk_pending}, 16'd0, "R9 clear");
        // R4 write qualifier
        drive(1'b0, 2'd1, 16'd0, 1'b0, 1'b0, 1'b1, 16'd0, 16'h1234);
        check({15'd0, brk_pending}, 16'd0, "R4 write ignored");
        wreg(2'd0, 16'h0006);
        drive(1'b0, 2'd1, 16'd0, 1'b0, 1'b0, 1'b1, 16'd0, 16'h1240);
        check({15'd0, brk_pending}, 16'd1, "R4 write match on B");
        clear_flag();
        // R6 enable
        wreg(2'd0, 16'h000B);
        dread(16'h1234);
        drive(1'b0, 2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 16'h1240, 16'd0);
        check({15'd0, brk_pending}, 16'd0, "R6 disabled");
        // R5 fetch qualifier
        wreg(2'd0, 16'h000C);
        dread(16'h1234);
        check({15'd0, brk_pending}, 16'd0, "R5 read ignored");
        drive(1'b0, 2'd1, 16'd0, 1'b1, 1'b0, 1'b0, 16'h1240, 16'd0);
        check({15'd0, brk_pending}, 16'd1, "R5 fetch match");
        clear_flag();
        // R7 equality only
        wreg(2'd0, 16'h0005);
        dread(16'h1238);
        check({15'd0, brk_pending}, 16'd0, "R7 between no match");
        // R8 range mode
        wreg(2'd0, 16'h0015);
        rreg(2'd0);
        check(rdata_nr, 16'h0005, "R8 no-range build bit4 zero");
        dread(16'h1238);
        check({15'd0, brk_pending}, 16'd1, "R8 inside window");
        check({15'd0, pend_nr}, 16'd0, "R8 no-range build ignores bit4");
        clear_flag();
        dread(16'h1233);
        check({15'd0, brk_pending}, 16'd0, "R8 below lower");
        dread(16'h1241);
        check({15'd0, brk_pending}, 16'd0, "R8 above upper");
        dread(16'h1240);
        check({15'd0, brk_pending}, 16'd1, "R8 upper inclusive");
        clear_flag();
        dread(16'h1234);
        check({15'd0, brk_pending}, 16'd1, "R8 lower inclusive");
        // R9 match and clear in the same cycle
        drive(1'b1, 2'd1, 16'h0001, 1'b0, 1'b1, 1'b0, 16'd0, 16'h1236);
        check({15'd0, brk_pending}, 16'd1, "R9 set beats clear");
        check({15'd0, halt_req}, 16'd0, "R10 no halt on held flag");
        clear_flag();
        check({15'd0, brk_pending}, 16'd0, "R9 final clear");
        rreg(2'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule